// File: doc/BRIEF.md
# Fault Status Report Sequencer

This block assembles the eight-bit status word that a serial host receives at the start of every transfer frame. It gathers three chip-wide fault conditions (charge-pump undervoltage, thermal warning and logic-supply undervoltage) and the latched load faults of up to four output channels, each channel carrying open-load, short-to-battery and short-to-ground flags.

Chip-wide conditions are captured into sticky flags, so that a short glitch is still seen by the host; a flag is released only once a frame has carried it out. Only one channel's load faults fit in a word, so when several channels are faulty the block visits them one per frame in rising channel order, wrapping back to the lowest, and writes the channel number into the top two bits of the word. An active-low summary line, meant to drive an open-drain pad, is pulled low whenever any fault is present.

The word is captured on the clock edge that sees the frame-start strobe and then held until the next strobe.

Top module: `fault_report_seq`

## Requirements
- R1: While reset is asserted and after it is released, the status word reads 0x00 and the summary line is high. The first frame after reset reports the lowest-numbered faulty channel.
- R2: A frame taken with no live, latched or load fault yields 0x00.
- R3: With only chip-wide faults, bits 7:6 are 00, bit 4 shows charge-pump undervoltage and bit 3 shows thermal warning (both together give 0x18).
- R4: With one faulty channel, bits 2, 1 and 0 carry its open-load, short-to-battery and short-to-ground flags, and bits 7:6 carry its index, where 00 is the first channel. Bits 7:6 are nonzero only when a load flag is set. These bits are merged with the chip-wide bits into one word: short-to-battery on the third channel gives 0x82, and charge-pump undervoltage with short-to-ground on the second channel gives 0x51.
- R5: With several faulty channels, successive frames report them in rising order and wrap to the lowest. With faults on the second, third and fourth channels the words are 0x41, 0x81, 0xC1 and then 0x41 again.
- R6: A chip-wide condition that clears before a frame stays set, and keeps the summary line low, until one frame has reported it. The frame after that no longer shows it.
- R7: A chip-wide condition that is still active at a frame start stays reported in later frames.
- R8: The summary line is low whenever any chip-wide condition is live or latched, or any channel has a load flag. It is high otherwise.
- R9: Bit 5 of the status word is always 0.
- R10: The status word changes only on a frame start.
- R11: The search for the next channel starts after the channel reported last. If that channel is the second one and the first and third become faulty, the next words are 0x84 (open load, third channel), then 0x01, then 0x84.
- R12: Logic-supply undervoltage is latched and pulls the summary line low. It has no bit in the status word and is released by the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe marking a frame start |
| cpuv_live | input | 1 | Live charge-pump undervoltage |
| therm_live | input | 1 | Live thermal warning |
| supuv_live | input | 1 | Live logic-supply undervoltage |
| ld_open | input | NCH | Latched open-load flag per channel |
| ld_bat | input | NCH | Latched short-to-battery flag per channel |
| ld_gnd | input | NCH | Latched short-to-ground flag per channel |
| status_byte | output | 8 | Status word captured at the last frame start |
| fault_n | output | 1 | Active-low fault summary |

## Verification
The bench builds the block with NCH = 4, the largest channel count that the two-bit address field can hold. This puts every address code within reach, including the wrap from the fourth channel back to a lower one. With four channels, a search can also skip over both faulty and clean channels, so the resumed search of R11 can be tested. Timing of sticky release is checked against frames that arrive both while a condition is live and after it has cleared.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int ADDR_W = 2;
    localparam int NSYS   = 3;
    localparam int MAX_CH = 1 << ADDR_W;

    typedef enum int {
        SYS_CPUV  = 0,
        SYS_THERM = 1,
        SYS_SUPUV = 2
    } sys_idx_e;

    typedef struct packed {
        logic open_ld;
        logic short_bat;
        logic short_gnd;
    } load_flt_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rsvd;
        logic              cp_uv;
        logic              therm;
        logic              open_ld;
        logic              short_bat;
        logic              short_gnd;
    } stat_byte_t;

    function automatic stat_byte_t pack_status(
        input logic [ADDR_W-1:0] addr,
        input logic [NSYS-1:0]   sys,
        input load_flt_t         ld,
        input logic              hit
    );
        stat_byte_t s;
        s.addr      = hit ? addr : '0;
        s.rsvd      = 1'b0;
        s.cp_uv     = sys[SYS_CPUV];
        s.therm     = sys[SYS_THERM];
        s.open_ld   = hit & ld.open_ld;
        s.short_bat = hit & ld.short_bat;
        s.short_gnd = hit & ld.short_gnd;
        return s;
    endfunction

endpackage

// File: rtl/fsr_sys_latch.sv
module fsr_sys_latch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         consume,
    input  logic [W-1:0] live,
    output logic [W-1:0] seen
);
    logic [W-1:0] sticky_q;

    // a live condition always wins over a release in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            sticky_q <= '0;
        else
            sticky_q <= live | (sticky_q & ~{W{consume}});
    end

    assign seen = sticky_q | live;
endmodule

// File: rtl/fsr_rotor.sv
module fsr_rotor #(
    parameter int NCH   = 4,
    parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic [NCH-1:0]   hit_vec,
    output logic [IDX_W-1:0] sel_idx,
    output logic             sel_hit
);
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] cand;
    logic             found;

    // forward search beginning one past the channel reported last
    always_comb begin
        cand  = '0;
        found = 1'b0;
        for (int k = 1; k <= NCH; k++) begin
            int j;
            j = (int'(last_q) + k) % NCH;
            if (!found && hit_vec[j]) begin
                found = 1'b1;
                cand  = IDX_W'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= IDX_W'(NCH - 1);
        else if (advance && found)
            last_q <= cand;
    end

    assign sel_idx = cand;
    assign sel_hit = found;
endmodule

// File: rtl/fault_report_seq.sv
module fault_report_seq
    import fsr_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           frame_start,
    input  logic           cpuv_live,
    input  logic           therm_live,
    input  logic           supuv_live,
    input  logic [NCH-1:0] ld_open,
    input  logic [NCH-1:0] ld_bat,
    input  logic [NCH-1:0] ld_gnd,
    output logic [7:0]     status_byte,
    output logic           fault_n
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    initial begin
        if (NCH < 1 || NCH > MAX_CH)
            $error("NCH must lie between 1 and %0d", MAX_CH);
    end

    logic [NSYS-1:0]  sys_live;
    logic [NSYS-1:0]  sys_seen;
    load_flt_t        ch_flt [NCH];
    logic [NCH-1:0]   ch_hit;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_hit;
    load_flt_t        sel_flt;
    stat_byte_t       stat_q;

    always_comb begin
        sys_live            = '0;
        sys_live[SYS_CPUV]  = cpuv_live;
        sys_live[SYS_THERM] = therm_live;
        sys_live[SYS_SUPUV] = supuv_live;
    end

    fsr_sys_latch #(.W(NSYS)) u_sys (
        .clk     (clk),
        .rst     (rst),
        .consume (frame_start),
        .live    (sys_live),
        .seen    (sys_seen)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_flt[i] = '{open_ld: ld_open[i], short_bat: ld_bat[i], short_gnd: ld_gnd[i]};
        assign ch_hit[i] = ld_open[i] | ld_bat[i] | ld_gnd[i];
    end

    fsr_rotor #(.NCH(NCH), .IDX_W(IDX_W)) u_rot (
        .clk     (clk),
        .rst     (rst),
        .advance (frame_start),
        .hit_vec (ch_hit),
        .sel_idx (sel_idx),
        .sel_hit (sel_hit)
    );

    assign sel_flt = ch_flt[sel_idx];

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else if (frame_start)
            stat_q <= pack_status(ADDR_W'(sel_idx), sys_seen, sel_flt, sel_hit);
    end

    assign status_byte = stat_q;
    assign fault_n     = ~((|sys_seen) | (|ch_hit));
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           frame_start,
    input logic           cpuv_live,
    input logic           therm_live,
    input logic           supuv_live,
    input logic [NCH-1:0] ld_open,
    input logic [NCH-1:0] ld_bat,
    input logic [NCH-1:0] ld_gnd,
    input logic [7:0]     status_byte,
    input logic           fault_n
);
    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (rst)
        status_byte[5] == 1'b0);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(status_byte));

    p_load_summary_r8: assert property (@(posedge clk) disable iff (rst)
        (|(ld_open | ld_bat | ld_gnd)) |-> !fault_n);

    p_sys_summary_r8: assert property (@(posedge clk) disable iff (rst)
        (cpuv_live | therm_live | supuv_live) |-> !fault_n);

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cpuv_live) && !$past(frame_start)) |-> !fault_n);

    p_addr_load_r4: assert property (@(posedge clk) disable iff (rst)
        (status_byte[7:6] != 2'b00) |-> (status_byte[2:0] != 3'b000));

    p_cpuv_report_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_start && cpuv_live) |=> status_byte[4]);
endmodule

bind fault_report_seq fsr_checker #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .cpuv_live   (cpuv_live),
    .therm_live  (therm_live),
    .supuv_live  (supuv_live),
    .ld_open     (ld_open),
    .ld_bat      (ld_bat),
    .ld_gnd      (ld_gnd),
    .status_byte (status_byte),
    .fault_n     (fault_n)
);

// File: tb/fault_report_seq_test.sv
module fault_report_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           frame_start = 1'b0;
    logic           cpuv_live = 1'b0;
    logic           therm_live = 1'b0;
    logic           supuv_live = 1'b0;
    logic [NCH-1:0] ld_open = '0;
    logic [NCH-1:0] ld_bat = '0;
    logic [NCH-1:0] ld_gnd = '0;
    logic [7:0]     status_byte;
    logic           fault_n;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_report_seq #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .cpuv_live(cpuv_live), .therm_live(therm_live), .supuv_live(supuv_live),
        .ld_open(ld_open), .ld_bat(ld_bat), .ld_gnd(ld_gnd),
        .status_byte(status_byte), .fault_n(fault_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    // strobe one frame; returns at the negedge after the capturing edge
    task automatic frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic clear_all();
        cpuv_live = 0; therm_live = 0; supuv_live = 0;
        ld_open = '0; ld_bat = '0; ld_gnd = '0;
        frame();
        frame();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 byte in reset", status_byte, 8'h00);
        chk("R1 summary in reset", {7'd0, fault_n}, 8'h01);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 byte after reset", status_byte, 8'h00);
    endtask

    task automatic t_idle();
        frame();
        chk("R2 no faults", status_byte, 8'h00);
        chk("R8 summary idle", {7'd0, fault_n}, 8'h01);
    endtask

    task automatic t_sticky();
        @(negedge clk) cpuv_live = 1'b1;
        @(negedge clk) cpuv_live = 1'b0;
        @(negedge clk);
        chk("R6 summary held after glitch", {7'd0, fault_n}, 8'h00);
        frame();
        chk("R3 cp undervoltage alone", status_byte, 8'h10);
        chk("R6 released after report", {7'd0, fault_n}, 8'h01);
        frame();
        chk("R6 not shown again", status_byte, 8'h00);
    endtask

    task automatic t_live_held();
        cpuv_live = 1'b1; therm_live = 1'b1;
        frame();
        chk("R3 both system flags", status_byte, 8'h18);
        frame();
        chk("R7 still live", status_byte, 8'h18);
        cpuv_live = 1'b0; therm_live = 1'b0;
        frame();
        chk("R6 latched after drop", status_byte, 8'h18);
        frame();
        chk("R6 cleared", status_byte, 8'h00);
        chk("R9 bit5 zero", {7'd0, status_byte[5]}, 8'h00);
    endtask

    task automatic t_single();
        ld_bat = 4'b0100;
        frame();
        chk("R4 stb third channel", status_byte, 8'h82);
        ld_bat = '0; ld_gnd = 4'b0010; cpuv_live = 1'b1;
        frame();
        chk("R4 cpuv plus stg second channel", status_byte, 8'h51);
        chk("R8 summary with load", {7'd0, fault_n}, 8'h00);
        clear_all();
        chk("R2 cleared again", status_byte, 8'h00);
    endtask

    task automatic t_rotate();
        do_reset();
        ld_gnd = 4'b1110;
        frame();
        chk("R1 R5 first after reset", status_byte, 8'h41);
        frame();
        chk("R5 third channel", status_byte, 8'h81);
        frame();
        chk("R5 fourth channel", status_byte, 8'hC1);
        frame();
        chk("R5 wrap", status_byte, 8'h41);
    endtask

    task automatic t_resume();
        ld_gnd = 4'b0001; ld_open = 4'b0100;
        frame();
        chk("R11 resume after second", status_byte, 8'h84);
        frame();
        chk("R11 wrap to first", status_byte, 8'h01);
        frame();
        chk("R11 back to third", status_byte, 8'h84);
        @(negedge clk) ld_gnd = 4'b1000; ld_open = '0; therm_live = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 held without frame", status_byte, 8'h84);
        clear_all();
    endtask

    task automatic t_supply();
        @(negedge clk) supuv_live = 1'b1;
        @(negedge clk) supuv_live = 1'b0;
        @(negedge clk);
        chk("R12 summary latched", {7'd0, fault_n}, 8'h00);
        frame();
        chk("R12 no status bit", status_byte, 8'h00);
        chk("R12 released by frame", {7'd0, fault_n}, 8'h01);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        t_reset();
        t_idle();
        t_sticky();
        t_live_held();
        t_single();
        t_rotate();
        t_resume();
        t_supply();
        summary();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule